// File: doc/BRIEF.md
# Byte-Wide Data Memory with Pointer Redirection

This block is the 256-location, 8-bit data space of a small controller core. Most of the low part of the map is sparse. Two pointer registers and an accumulator hold real storage. General-purpose RAM fills the upper part of the map. Two phantom locations have no storage: any access to them lands on the location named by the matching pointer. The core uses this to walk tables through a pointer instead of a fixed address.

One port serves every operation. In each cycle it can do a byte read, a byte write, or a single-bit set or clear. A bit operation reads the target, changes one bit, and writes the result back in the same clock. It works on whatever location the access resolves to, so a bit can be flipped through a pointer as well. When a pointer names a phantom location, nothing is accessed: the read gives zero and any change is dropped.

Top module: `rf_indirect`

## Requirements
- R1: Pointer A lives at address 01H and pointer B at 02H. Both are 8-bit registers that read back what was last written to them.
- R2: The accumulator lives at address 05H and reads back what was last written to it.
- R3: Addresses from the RAM base (40H by default) up to FFH are byte RAM that reads back the last value written.
- R4: Address 00H is phantom A and address 03H is phantom B. A read or write there acts on the location whose address is held in pointer A or pointer B. This includes the case where the pointer names the other pointer.
- R5: When a phantom access resolves to 00H or 03H, the read returns 00H. Writes and bit operations have no effect on any location.
- R6: Address 04H and addresses 06H to 3FH hold no storage. They read 00H, and writes or bit operations there change nothing.
- R7: bit_set forces bit bit_idx (0 = LSB, 7 = MSB) of the resolved location to 1. bit_clr forces it to 0. Both act in one clock and leave the other seven bits unchanged.
- R8: When several update strobes are asserted together, wr_en wins over bit_clr, and bit_clr wins over bit_set.
- R9: rdata is combinational. It shows the resolved location's content in the same cycle while rd_en is high, and it is 00H while rd_en is low.
- R10: A synchronous active-high reset clears both pointers and the accumulator. Reset leaves RAM contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Location addressed this cycle |
| wdata | input | 8 | Byte to write |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Read enable for rdata |
| bit_set | input | 1 | Set one bit of the resolved location |
| bit_clr | input | 1 | Clear one bit of the resolved location |
| bit_idx | input | 3 | Bit selected by bit_set or bit_clr |
| rdata | output | 8 | Read data, combinational |

## Verification
The bench builds the block with its default RAM base of 40H. At that base, both ends of the RAM window (40H and FFH) and the gap below it (04H, 06H–3FH) can be reached by plain addresses. With the 8-bit data width, bit indices 0 through 7 all land on real bits. Aiming the pointers at each other and at the phantom locations exercises chained redirection and the zero-read / dropped-write rule.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int BW = $clog2(DW);

    localparam logic [AW-1:0] PHANTOM_A = 8'h00;
    localparam logic [AW-1:0] POINTER_A = 8'h01;
    localparam logic [AW-1:0] POINTER_B = 8'h02;
    localparam logic [AW-1:0] PHANTOM_B = 8'h03;
    localparam logic [AW-1:0] ACCUM     = 8'h05;

    typedef enum logic [2:0] {
        LOC_NONE,
        LOC_PTRA,
        LOC_PTRB,
        LOC_ACC,
        LOC_RAM
    } loc_e;

    typedef struct packed {
        loc_e          loc;
        logic [AW-1:0] ea;
    } target_t;

    function automatic logic is_phantom(input logic [AW-1:0] a);
        return (a == PHANTOM_A) || (a == PHANTOM_B);
    endfunction

    function automatic loc_e classify(input logic [AW-1:0] a,
                                      input logic [AW-1:0] ram_base);
        if (a == POINTER_A)     return LOC_PTRA;
        if (a == POINTER_B)     return LOC_PTRB;
        if (a == ACCUM)         return LOC_ACC;
        if (a >= ram_base)      return LOC_RAM;
        return LOC_NONE;
    endfunction

endpackage

// File: rtl/rf_addr_resolve.sv
module rf_addr_resolve
    import rf_pkg::*;
#(
    parameter logic [AW-1:0] RAM_BASE = 8'h40
) (
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] ptr_a,
    input  logic [DW-1:0] ptr_b,
    output target_t       tgt
);
    logic          via_ptr;
    logic [AW-1:0] ea;

    always_comb begin
        via_ptr = is_phantom(addr);
        if (addr == PHANTOM_A)      ea = ptr_a;
        else if (addr == PHANTOM_B) ea = ptr_b;
        else                        ea = addr;
    end

    always_comb begin
        tgt.ea = ea;
        if (via_ptr && is_phantom(ea)) tgt.loc = LOC_NONE;
        else                           tgt.loc = classify(ea, RAM_BASE);
    end

endmodule

// File: rtl/rf_bit_update.sv
module rf_bit_update
    import rf_pkg::*;
(
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] wdata,
    input  logic          wr_en,
    input  logic          bit_set,
    input  logic          bit_clr,
    input  logic [BW-1:0] bit_idx,
    output logic [DW-1:0] nxt,
    output logic          commit
);
    assign commit = wr_en | bit_set | bit_clr;

    for (genvar b = 0; b < DW; b++) begin : g_bit
        logic hit;
        assign hit = (bit_idx == BW'(b));
        always_comb begin
            if (wr_en)               nxt[b] = wdata[b];
            else if (bit_clr && hit) nxt[b] = 1'b0;
            else if (bit_set && hit) nxt[b] = 1'b1;
            else                     nxt[b] = cur[b];
        end
    end

endmodule

// File: rtl/rf_storage.sv
module rf_storage
    import rf_pkg::*;
#(
    parameter logic [AW-1:0] RAM_BASE = 8'h40
) (
    input  logic          clk,
    input  logic          rst,
    input  target_t       tgt,
    input  logic          commit,
    input  logic [DW-1:0] nxt,
    output logic [DW-1:0] rd_val,
    output logic [DW-1:0] ptr_a_q,
    output logic [DW-1:0] ptr_b_q,
    output logic [DW-1:0] acc_q
);
    localparam int RAM_DEPTH = (2 ** AW) - int'(RAM_BASE);
    localparam int IW        = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;

    logic [DW-1:0] ram [RAM_DEPTH];
    logic [AW-1:0] off;
    logic [IW-1:0] idx;

    assign off = tgt.ea - RAM_BASE;
    assign idx = off[IW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_a_q <= '0;
            ptr_b_q <= '0;
            acc_q   <= '0;
        end else if (commit) begin
            case (tgt.loc)
                LOC_PTRA: ptr_a_q <= nxt;
                LOC_PTRB: ptr_b_q <= nxt;
                LOC_ACC:  acc_q   <= nxt;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && commit && tgt.loc == LOC_RAM)
            ram[idx] <= nxt;
    end

    always_comb begin
        case (tgt.loc)
            LOC_PTRA: rd_val = ptr_a_q;
            LOC_PTRB: rd_val = ptr_b_q;
            LOC_ACC:  rd_val = acc_q;
            LOC_RAM:  rd_val = ram[idx];
            default:  rd_val = '0;
        endcase
    end

endmodule

// File: rtl/rf_indirect.sv
module rf_indirect
    import rf_pkg::*;
#(
    parameter logic [7:0] RAM_BASE = 8'h40
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       bit_set,
    input  logic       bit_clr,
    input  logic [2:0] bit_idx,
    output logic [7:0] rdata
);
    target_t       tgt;
    logic [DW-1:0] rd_val;
    logic [DW-1:0] nxt;
    logic          commit;
    logic [DW-1:0] ptr_a_q;
    logic [DW-1:0] ptr_b_q;
    logic [DW-1:0] acc_q;

    rf_addr_resolve #(.RAM_BASE(RAM_BASE)) u_resolve (
        .addr  (addr),
        .ptr_a (ptr_a_q),
        .ptr_b (ptr_b_q),
        .tgt   (tgt)
    );

    rf_bit_update u_update (
        .cur     (rd_val),
        .wdata   (wdata),
        .wr_en   (wr_en),
        .bit_set (bit_set),
        .bit_clr (bit_clr),
        .bit_idx (bit_idx),
        .nxt     (nxt),
        .commit  (commit)
    );

    rf_storage #(.RAM_BASE(RAM_BASE)) u_store (
        .clk     (clk),
        .rst     (rst),
        .tgt     (tgt),
        .commit  (commit),
        .nxt     (nxt),
        .rd_val  (rd_val),
        .ptr_a_q (ptr_a_q),
        .ptr_b_q (ptr_b_q),
        .acc_q   (acc_q)
    );

    assign rdata = rd_en ? rd_val : '0;

endmodule

// File: rtl/rf_indirect_chk.sv
module rf_indirect_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] addr,
    input logic [7:0] wdata,
    input logic       wr_en,
    input logic       rd_en,
    input logic       bit_set,
    input logic       bit_clr,
    input logic [2:0] bit_idx,
    input logic [7:0] rdata,
    input logic [7:0] ptr_a_q,
    input logic [7:0] ptr_b_q,
    input logic [7:0] acc_q
);
    logic gap_addr;
    logic any_upd;
    logic dead_ind;

    assign gap_addr = (addr == 8'h04) || (addr >= 8'h06 && addr < 8'h40);
    assign any_upd  = wr_en | bit_set | bit_clr;
    assign dead_ind = (addr == 8'h00 && (ptr_a_q == 8'h00 || ptr_a_q == 8'h03)) ||
                      (addr == 8'h03 && (ptr_b_q == 8'h00 || ptr_b_q == 8'h03));

    // R1
    ptr_a_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr == 8'h01 |=> ptr_a_q == $past(wdata));

    // R1
    ptr_b_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr == 8'h02 |=> ptr_b_q == $past(wdata));

    // R2 and R8: a byte write wins over any bit strobe
    acc_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr == 8'h05 |=> acc_q == $past(wdata));

    // R5
    dead_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && dead_ind |-> rdata == 8'h00);

    // R5
    dead_write_chk: assert property (@(posedge clk) disable iff (rst)
        any_upd && dead_ind |=> $stable(ptr_a_q) && $stable(ptr_b_q) && $stable(acc_q));

    // R6
    gap_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && gap_addr |-> rdata == 8'h00);

    // R6
    gap_write_chk: assert property (@(posedge clk) disable iff (rst)
        any_upd && gap_addr |=> $stable(ptr_a_q) && $stable(ptr_b_q) && $stable(acc_q));

    // R9
    idle_read_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rdata == 8'h00);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> ptr_a_q == 8'h00 && ptr_b_q == 8'h00 && acc_q == 8'h00);

endmodule

bind rf_indirect rf_indirect_chk u_chk (.*);

// File: tb/tb_rf_indirect.sv
module tb_rf_indirect;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic       wr_en;
    logic       rd_en;
    logic       bit_set;
    logic       bit_clr;
    logic [2:0] bit_idx;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rf_indirect dut (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wdata   (wdata),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .bit_set (bit_set),
        .bit_clr (bit_clr),
        .bit_idx (bit_idx),
        .rdata   (rdata)
    );

    localparam logic [2:0] OP_W  = 3'd0;  // byte write
    localparam logic [2:0] OP_R  = 3'd1;  // read and compare
    localparam logic [2:0] OP_S  = 3'd2;  // bit set
    localparam logic [2:0] OP_C  = 3'd3;  // bit clear
    localparam logic [2:0] OP_SC = 3'd4;  // set and clear together
    localparam logic [2:0] OP_WS = 3'd5;  // write and set together
    localparam logic [2:0] OP_N  = 3'd6;  // rd_en low, expect zero

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] a;
        logic [7:0] d;
        logic [2:0] i;
        logic [7:0] e;
        logic [3:0] r;
    } vec_t;

    localparam int NV = 46;
    localparam vec_t TBL [NV] = '{
        '{OP_W , 8'h01, 8'h45, 3'd0, 8'h00, 4'd1},  // R1
        '{OP_W , 8'h02, 8'h80, 3'd0, 8'h00, 4'd1},  // R1
        '{OP_R , 8'h01, 8'h00, 3'd0, 8'h45, 4'd1},  // R1
        '{OP_R , 8'h02, 8'h00, 3'd0, 8'h80, 4'd1},  // R1
        '{OP_W , 8'h00, 8'hA5, 3'd0, 8'h00, 4'd4},  // R4 phantom A -> 45H
        '{OP_R , 8'h45, 8'h00, 3'd0, 8'hA5, 4'd4},  // R4
        '{OP_R , 8'h00, 8'h00, 3'd0, 8'hA5, 4'd4},  // R4
        '{OP_W , 8'h03, 8'h3C, 3'd0, 8'h00, 4'd4},  // R4 phantom B -> 80H
        '{OP_R , 8'h80, 8'h00, 3'd0, 8'h3C, 4'd4},  // R4
        '{OP_R , 8'h03, 8'h00, 3'd0, 8'h3C, 4'd4},  // R4
        '{OP_W , 8'h05, 8'h7E, 3'd0, 8'h00, 4'd2},  // R2
        '{OP_R , 8'h05, 8'h00, 3'd0, 8'h7E, 4'd2},  // R2
        '{OP_S , 8'h05, 8'h00, 3'd0, 8'h00, 4'd7},  // R7 set LSB
        '{OP_R , 8'h05, 8'h00, 3'd0, 8'h7F, 4'd7},  // R7
        '{OP_C , 8'h05, 8'h00, 3'd6, 8'h00, 4'd7},  // R7 clear bit 6
        '{OP_R , 8'h05, 8'h00, 3'd0, 8'h3F, 4'd7},  // R7
        '{OP_S , 8'h00, 8'h00, 3'd1, 8'h00, 4'd7},  // R7 through pointer A
        '{OP_R , 8'h45, 8'h00, 3'd0, 8'hA7, 4'd7},  // R7
        '{OP_C , 8'h03, 8'h00, 3'd2, 8'h00, 4'd7},  // R7 through pointer B
        '{OP_R , 8'h80, 8'h00, 3'd0, 8'h38, 4'd7},  // R7
        '{OP_W , 8'h01, 8'h03, 3'd0, 8'h00, 4'd5},  // R5 pointer A -> phantom B
        '{OP_R , 8'h00, 8'h00, 3'd0, 8'h00, 4'd5},  // R5 reads zero
        '{OP_W , 8'h00, 8'hFF, 3'd0, 8'h00, 4'd5},  // R5 dropped write
        '{OP_R , 8'h80, 8'h00, 3'd0, 8'h38, 4'd5},  // R5
        '{OP_R , 8'h02, 8'h00, 3'd0, 8'h80, 4'd5},  // R5
        '{OP_R , 8'h05, 8'h00, 3'd0, 8'h3F, 4'd5},  // R5
        '{OP_S , 8'h00, 8'h00, 3'd7, 8'h00, 4'd5},  // R5 dropped bit set
        '{OP_R , 8'h80, 8'h00, 3'd0, 8'h38, 4'd5},  // R5
        '{OP_W , 8'h01, 8'h02, 3'd0, 8'h00, 4'd4},  // R4 pointer A -> pointer B
        '{OP_W , 8'h00, 8'h90, 3'd0, 8'h00, 4'd4},  // R4
        '{OP_R , 8'h02, 8'h00, 3'd0, 8'h90, 4'd4},  // R4
        '{OP_W , 8'h20, 8'h55, 3'd0, 8'h00, 4'd6},  // R6
        '{OP_R , 8'h20, 8'h00, 3'd0, 8'h00, 4'd6},  // R6
        '{OP_R , 8'h04, 8'h00, 3'd0, 8'h00, 4'd6},  // R6
        '{OP_R , 8'h3F, 8'h00, 3'd0, 8'h00, 4'd6},  // R6
        '{OP_R , 8'h05, 8'h00, 3'd0, 8'h3F, 4'd6},  // R6
        '{OP_W , 8'hFF, 8'hC3, 3'd0, 8'h00, 4'd3},  // R3 top of RAM
        '{OP_W , 8'h40, 8'h11, 3'd0, 8'h00, 4'd3},  // R3 base of RAM
        '{OP_R , 8'hFF, 8'h00, 3'd0, 8'hC3, 4'd3},  // R3
        '{OP_R , 8'h40, 8'h00, 3'd0, 8'h11, 4'd3},  // R3
        '{OP_SC, 8'h40, 8'h00, 3'd0, 8'h00, 4'd8},  // R8 clear wins
        '{OP_R , 8'h40, 8'h00, 3'd0, 8'h10, 4'd8},  // R8
        '{OP_WS, 8'h40, 8'h22, 3'd7, 8'h00, 4'd8},  // R8 write wins
        '{OP_R , 8'h40, 8'h00, 3'd0, 8'h22, 4'd8},  // R8
        '{OP_N , 8'h40, 8'h00, 3'd0, 8'h00, 4'd9},  // R9 rd_en low
        '{OP_R , 8'h01, 8'h00, 3'd0, 8'h02, 4'd9}   // R9 same-cycle read
    };

    task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d addr=%h got=%h expected=%h", req, addr, got, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; bit_set = 0; bit_clr = 0;
        addr = '0; wdata = '0; bit_idx = '0;
    endtask

    task automatic rd_chk(input int req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        idle();
        addr = a; rd_en = 1;
        #1 check(req, rdata, exp);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R10 reset state
        rd_chk(10, 8'h01, 8'h00);
        rd_chk(10, 8'h02, 8'h00);
        rd_chk(10, 8'h05, 8'h00);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            idle();
            addr    = TBL[k].a;
            wdata   = TBL[k].d;
            bit_idx = TBL[k].i;
            case (TBL[k].op)
                OP_W:    wr_en = 1;
                OP_R:    rd_en = 1;
                OP_S:    bit_set = 1;
                OP_C:    bit_clr = 1;
                OP_SC:   begin bit_set = 1; bit_clr = 1; end
                OP_WS:   begin wr_en = 1; bit_set = 1; end
                default: ;
            endcase
            #1;
            if (TBL[k].op == OP_R || TBL[k].op == OP_N)
                check(int'(TBL[k].r), rdata, TBL[k].e);
        end

        // R10 second reset: registers clear, RAM keeps its data
        @(negedge clk);
        idle();
        wr_en = 1; addr = 8'h05; wdata = 8'hEE;
        @(negedge clk);
        idle();
        rst = 1;
        @(negedge clk) rst = 0;
        rd_chk(10, 8'h01, 8'h00);
        rd_chk(10, 8'h02, 8'h00);
        rd_chk(10, 8'h05, 8'h00);
        rd_chk(10, 8'h40, 8'h22);
        rd_chk(10, 8'hFF, 8'hC3);

        // R7 highest bit index through a pointer aimed at RAM top
        @(negedge clk); idle(); wr_en = 1; addr = 8'h02; wdata = 8'hFF;
        @(negedge clk); idle(); bit_clr = 1; addr = 8'h03; bit_idx = 3'd7;
        rd_chk(7, 8'hFF, 8'h43);

        @(negedge clk);
        idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule